// File: doc/BRIEF.md
# Interrupt Exception Entry and Return Unit

This unit owns the status register of a small processor core and performs the state changes around an interrupt. When the core accepts an interrupt, the unit captures the current program counter, status register and one general register into three shadow registers in one clock edge. On the same edge it forces the block, privilege and bank bits of the status register high, stores the event code and issues a redirect to the handler entry point, which is the vector base plus 0x600.

A return command reloads the status register from its shadow copy and redirects fetch to the saved program counter. The saved general register is kept for the handler to read and is never written back. The core also writes the status register directly through a write port, which yields to entry and to return.

The status register bit positions are: privilege mode at bit 30, bank select at bit 29, block at bit 28 and FPU disable at bit 15. Priority arbitration among interrupt sources, the pipeline and the register file sit outside this unit.

Top module: `irq_entry_unit`

## Requirements
- R1: On an accepted entry, `spc_q`, `ssr_q` and `sgr_q` take the values of `cur_pc`, `sr_q` and `cur_gr` sampled on that same edge, so `ssr_q` holds the status value from before entry.
- R2: After an accepted entry, status bits 30 (mode), 29 (bank) and 28 (block) are 1, and every other bit except bit 15 keeps its pre-entry value.
- R3: Bit 15 (FPU disable) is cleared by an entry with `take_is_reset` high and left unchanged by any other entry.
- R4: After an accepted entry, `evt_q` bits 13:0 hold `take_code` and bits 31:14 are zero.
- R5: An accepted entry raises `redir_vld` for exactly one cycle, with `redir_addr` equal to `vbr + 0x600`.
- R6: A return command (without a same-cycle entry request) reloads `sr_q` from `ssr_q` and gives a one-cycle `redir_vld` with `redir_addr` equal to `spc_q`.
- R7: A return leaves `sgr_q` unchanged, and the unit has no path that writes it back to the general register.
- R8: An entry request without `take_is_reset` while status bit 28 is 1 is ignored: the shadow registers, the status register and `redir_vld` do not change.
- R9: When entry and return are requested in the same cycle, the return is dropped, the entry proceeds if it is accepted, and `clash_err` pulses high for one cycle.
- R10: Synchronous reset sets `sr_q` to 0x7000_0000, clears the shadow and event registers, and drives `redir_vld` and `clash_err` low.
- R11: With `sr_wr_en` high, `sr_q` takes `sr_wr_data` on the next edge, unless an accepted entry or a return occurs in that cycle, which takes precedence.
- R12: An entry with `take_is_reset` high is accepted even while status bit 28 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_req | input | 1 | Interrupt acceptance request |
| take_code | input | 14 | Event code of the request |
| take_is_reset | input | 1 | Request is a reset-type event |
| ret_req | input | 1 | Return-from-exception command |
| sr_wr_en | input | 1 | Core write to the status register |
| sr_wr_data | input | 32 | Status write data |
| cur_pc | input | 32 | Current program counter |
| cur_gr | input | 32 | Current value of the saved general register |
| vbr | input | 32 | Vector base address |
| sr_q | output | 32 | Status register |
| spc_q | output | 32 | Saved program counter |
| ssr_q | output | 32 | Saved status register |
| sgr_q | output | 32 | Saved general register |
| evt_q | output | 32 | Event register |
| redir_vld | output | 1 | One-cycle fetch redirect strobe |
| redir_addr | output | 32 | Fetch redirect target |
| clash_err | output | 1 | Entry and return requested together |

## Verification
Every result is one register stage from its stimulus: entry, return and status writes sampled at edge N appear on the outputs right after edge N, and `redir_vld` and `clash_err` fall again after edge N+1. The bench drives requests on a falling edge and checks on the next falling edge, then checks once more a cycle later to confirm that the strobes have fallen and that blocked requests left the state untouched. A sweep over 48 status, code, address and event-type patterns runs a write, an entry, a blocked retry and a return for each pattern, and the bench predicts every value arithmetically.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int SR_MD = 30;
  localparam int SR_RB = 29;
  localparam int SR_BL = 28;
  localparam int SR_FD = 15;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_ENTER  = 2'd1,
    ACT_RETURN = 2'd2,
    ACT_WRITE  = 2'd3
  } exc_act_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic     take_req,
  input  logic     take_is_reset,
  input  logic     blocked,
  input  logic     ret_req,
  input  logic     sr_wr_en,
  output exc_act_e act,
  output logic     clash
);
  logic accept;

  assign accept = take_req && (!blocked || take_is_reset);
  assign clash  = take_req && ret_req;

  always_comb begin
    if (accept)                    act = ACT_ENTER;
    else if (ret_req && !take_req) act = ACT_RETURN;
    else if (sr_wr_en && !ret_req) act = ACT_WRITE;
    else                           act = ACT_NONE;
  end
endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_pkg::*;
#(
  parameter int             XLEN   = 32,
  parameter logic [XLEN-1:0] SR_RST = 32'h7000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  exc_act_e        act,
  input  logic            is_reset,
  input  logic [XLEN-1:0] ssr_in,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] sr
);
  logic [XLEN-1:0] entered;

  always_comb begin
    entered        = sr;
    entered[SR_BL] = 1'b1;
    entered[SR_MD] = 1'b1;
    entered[SR_RB] = 1'b1;
    if (is_reset) entered[SR_FD] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= SR_RST;
    end else begin
      case (act)
        ACT_ENTER:  sr <= entered;
        ACT_RETURN: sr <= ssr_in;
        ACT_WRITE:  sr <= wr_data;
        default:    sr <= sr;
      endcase
    end
  end
endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   gr_in,
  input  logic [CODE_W-1:0] code_in,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   ssr,
  output logic [XLEN-1:0]   sgr,
  output logic [XLEN-1:0]   evt
);
  logic [XLEN-1:0] evt_next;

  generate
    if (CODE_W < XLEN) begin : g_pad
      assign evt_next = {{(XLEN-CODE_W){1'b0}}, code_in};
    end else begin : g_full
      assign evt_next = code_in[XLEN-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      spc <= '0;
      ssr <= '0;
      sgr <= '0;
      evt <= '0;
    end else if (enter) begin
      spc <= pc_in;
      ssr <= sr_in;
      sgr <= gr_in;
      evt <= evt_next;
    end
  end
endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
  import exc_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] VEC_OFF = 32'h600
) (
  input  logic            clk,
  input  logic            rst,
  input  exc_act_e        act,
  input  logic [XLEN-1:0] vbr,
  input  logic [XLEN-1:0] spc,
  output logic            vld,
  output logic [XLEN-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      addr <= '0;
    end else begin
      vld <= (act == ACT_ENTER) || (act == ACT_RETURN);
      if (act == ACT_ENTER)       addr <= vbr + VEC_OFF;
      else if (act == ACT_RETURN) addr <= spc;
    end
  end
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import exc_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter int              CODE_W  = 14,
  parameter logic [XLEN-1:0] VEC_OFF = 32'h600,
  parameter logic [XLEN-1:0] SR_RST  = 32'h7000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_req,
  input  logic [CODE_W-1:0] take_code,
  input  logic              take_is_reset,
  input  logic              ret_req,
  input  logic              sr_wr_en,
  input  logic [XLEN-1:0]   sr_wr_data,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_gr,
  input  logic [XLEN-1:0]   vbr,
  output logic [XLEN-1:0]   sr_q,
  output logic [XLEN-1:0]   spc_q,
  output logic [XLEN-1:0]   ssr_q,
  output logic [XLEN-1:0]   sgr_q,
  output logic [XLEN-1:0]   evt_q,
  output logic              redir_vld,
  output logic [XLEN-1:0]   redir_addr,
  output logic              clash_err
);
  exc_act_e act;
  logic     clash;

  exc_arbiter u_arb (
    .take_req      (take_req),
    .take_is_reset (take_is_reset),
    .blocked       (sr_q[SR_BL]),
    .ret_req       (ret_req),
    .sr_wr_en      (sr_wr_en),
    .act           (act),
    .clash         (clash)
  );

  exc_status_reg #(.XLEN(XLEN), .SR_RST(SR_RST)) u_sr (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .is_reset (take_is_reset),
    .ssr_in   (ssr_q),
    .wr_data  (sr_wr_data),
    .sr       (sr_q)
  );

  exc_save_bank #(.XLEN(XLEN), .CODE_W(CODE_W)) u_save (
    .clk     (clk),
    .rst     (rst),
    .enter   (act == ACT_ENTER),
    .pc_in   (cur_pc),
    .sr_in   (sr_q),
    .gr_in   (cur_gr),
    .code_in (take_code),
    .spc     (spc_q),
    .ssr     (ssr_q),
    .sgr     (sgr_q),
    .evt     (evt_q)
  );

  exc_redirect #(.XLEN(XLEN), .VEC_OFF(VEC_OFF)) u_redir (
    .clk  (clk),
    .rst  (rst),
    .act  (act),
    .vbr  (vbr),
    .spc  (spc_q),
    .vld  (redir_vld),
    .addr (redir_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) clash_err <= 1'b0;
    else     clash_err <= clash;
  end
endmodule

// File: rtl/irq_entry_checker.sv
module irq_entry_checker
  import exc_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter int              CODE_W  = 14,
  parameter logic [XLEN-1:0] VEC_OFF = 32'h600
) (
  input logic              clk,
  input logic              rst,
  input logic              take_req,
  input logic [CODE_W-1:0] take_code,
  input logic              take_is_reset,
  input logic              ret_req,
  input logic [XLEN-1:0]   cur_pc,
  input logic [XLEN-1:0]   cur_gr,
  input logic [XLEN-1:0]   vbr,
  input logic [XLEN-1:0]   sr_q,
  input logic [XLEN-1:0]   spc_q,
  input logic [XLEN-1:0]   ssr_q,
  input logic [XLEN-1:0]   sgr_q,
  input logic [XLEN-1:0]   evt_q,
  input logic              redir_vld,
  input logic [XLEN-1:0]   redir_addr,
  input logic              clash_err
);
  logic acc;
  assign acc = take_req && (!sr_q[SR_BL] || take_is_reset);

  assert_save_triple_R1: assert property (@(posedge clk) disable iff (rst)
    acc |=> (spc_q == $past(cur_pc)) && (ssr_q == $past(sr_q)) && (sgr_q == $past(cur_gr)));

  assert_mode_bits_R2: assert property (@(posedge clk) disable iff (rst)
    acc |=> sr_q[SR_BL] && sr_q[SR_MD] && sr_q[SR_RB]);

  assert_fd_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && take_is_reset) |=> !sr_q[SR_FD]);

  assert_event_code_R4: assert property (@(posedge clk) disable iff (rst)
    acc |=> evt_q == XLEN'($past(take_code)));

  assert_vector_R5: assert property (@(posedge clk) disable iff (rst)
    acc |=> redir_vld && (redir_addr == $past(vbr) + VEC_OFF));

  assert_restore_R6: assert property (@(posedge clk) disable iff (rst)
    (ret_req && !take_req) |=> redir_vld && (sr_q == $past(ssr_q)) && (redir_addr == $past(spc_q)));

  assert_keep_sgr_R7: assert property (@(posedge clk) disable iff (rst)
    (ret_req && !take_req) |=> sgr_q == $past(sgr_q));

  assert_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    (take_req && sr_q[SR_BL] && !take_is_reset) |=> (spc_q == $past(spc_q)) && (ssr_q == $past(ssr_q)));

  assert_clash_R9: assert property (@(posedge clk) disable iff (rst)
    (take_req && ret_req) |=> clash_err);
endmodule

bind irq_entry_unit irq_entry_checker #(.XLEN(XLEN), .CODE_W(CODE_W), .VEC_OFF(VEC_OFF)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .take_req      (take_req),
  .take_code     (take_code),
  .take_is_reset (take_is_reset),
  .ret_req       (ret_req),
  .cur_pc        (cur_pc),
  .cur_gr        (cur_gr),
  .vbr           (vbr),
  .sr_q          (sr_q),
  .spc_q         (spc_q),
  .ssr_q         (ssr_q),
  .sgr_q         (sgr_q),
  .evt_q         (evt_q),
  .redir_vld     (redir_vld),
  .redir_addr    (redir_addr),
  .clash_err     (clash_err)
);

// File: tb/test_irq_entry_unit.sv
module test_irq_entry_unit;
  localparam logic [31:0] BL = 32'h1000_0000;
  localparam logic [31:0] RB = 32'h2000_0000;
  localparam logic [31:0] MD = 32'h4000_0000;
  localparam logic [31:0] FD = 32'h0000_8000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        take_req = 1'b0;
  logic [13:0] take_code = '0;
  logic        take_is_reset = 1'b0;
  logic        ret_req = 1'b0;
  logic        sr_wr_en = 1'b0;
  logic [31:0] sr_wr_data = '0;
  logic [31:0] cur_pc = '0;
  logic [31:0] cur_gr = '0;
  logic [31:0] vbr = '0;
  logic [31:0] sr_q, spc_q, ssr_q, sgr_q, evt_q, redir_addr;
  logic        redir_vld, clash_err;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  irq_entry_unit i_irq_entry_unit (
    .clk(clk), .rst(rst), .take_req(take_req), .take_code(take_code),
    .take_is_reset(take_is_reset), .ret_req(ret_req), .sr_wr_en(sr_wr_en),
    .sr_wr_data(sr_wr_data), .cur_pc(cur_pc), .cur_gr(cur_gr), .vbr(vbr),
    .sr_q(sr_q), .spc_q(spc_q), .ssr_q(ssr_q), .sgr_q(sgr_q), .evt_q(evt_q),
    .redir_vld(redir_vld), .redir_addr(redir_addr), .clash_err(clash_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    take_req = 1'b0; ret_req = 1'b0; sr_wr_en = 1'b0; take_is_reset = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic write_sr(input logic [31:0] v);
    sr_wr_en = 1'b1; sr_wr_data = v;
    tick();
    chk("R11 sr write", sr_q, v);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_sr;
    logic [31:0] pre;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R10 sr reset", sr_q, 32'h7000_0000);
    chk("R10 spc reset", spc_q, 32'h0);
    chk("R10 ssr reset", ssr_q, 32'h0);
    chk("R10 sgr reset", sgr_q, 32'h0);
    chk("R10 evt reset", evt_q, 32'h0);
    chk("R10 redir reset", {31'b0, redir_vld}, 32'h0);
    chk("R10 clash reset", {31'b0, clash_err}, 32'h0);

    // R8: blocked after reset because BL is set
    take_req = 1'b1; take_code = 14'h123; cur_pc = 32'hDEAD_0000;
    tick();
    chk("R8 blocked spc", spc_q, 32'h0);
    chk("R8 blocked redir", {31'b0, redir_vld}, 32'h0);
    chk("R8 blocked sr", sr_q, 32'h7000_0000);

    for (int i = 0; i < 48; i++) begin
      pre = ((i * 32'h0103_0507) ^ ((i & 1) ? FD : 32'h0)) & ~BL;
      write_sr(pre);
      take_req = 1'b1;
      take_is_reset = (i % 3 == 0);
      take_code = 14'((i * 32'h155) ^ (i << 9));
      cur_pc = 32'h1000_0000 + i * 4;
      cur_gr = ~cur_pc;
      vbr = i << 12;
      exp_sr = pre | BL | MD | RB;
      if (i % 3 == 0) exp_sr = exp_sr & ~FD;
      tick();
      chk("R1 spc", spc_q, 32'h1000_0000 + i * 4);
      chk("R1 ssr", ssr_q, pre);
      chk("R1 sgr", sgr_q, ~(32'h1000_0000 + i * 4));
      chk("R2 R3 sr", sr_q, exp_sr);
      chk("R4 evt", evt_q, {18'b0, 14'((i * 32'h155) ^ (i << 9))});
      chk("R5 redir vld", {31'b0, redir_vld}, 32'h1);
      chk("R5 redir addr", redir_addr, (i << 12) + 32'h600);
      // R8: non-reset retry while BL=1
      take_req = 1'b1; cur_pc = 32'h5555_0000; cur_gr = 32'h0;
      tick();
      chk("R5 strobe falls", {31'b0, redir_vld}, 32'h0);
      chk("R8 spc kept", spc_q, 32'h1000_0000 + i * 4);
      chk("R8 sgr kept", sgr_q, ~(32'h1000_0000 + i * 4));
      ret_req = 1'b1;
      tick();
      chk("R6 sr restored", sr_q, pre);
      chk("R6 redir vld", {31'b0, redir_vld}, 32'h1);
      chk("R6 redir addr", redir_addr, 32'h1000_0000 + i * 4);
      chk("R7 sgr kept", sgr_q, ~(32'h1000_0000 + i * 4));
      tick();
      chk("R6 strobe falls", {31'b0, redir_vld}, 32'h0);
    end

    // R9: clash with BL clear, entry wins
    write_sr(32'h0000_0001);
    take_req = 1'b1; ret_req = 1'b1; take_code = 14'h2AA;
    cur_pc = 32'hCAFE_0010; cur_gr = 32'h1234_5678; vbr = 32'h8000_0000;
    tick();
    chk("R9 entry wins spc", spc_q, 32'hCAFE_0010);
    chk("R9 redir to vector", redir_addr, 32'h8000_0600);
    chk("R9 clash flag", {31'b0, clash_err}, 32'h1);
    chk("R9 sr entered", sr_q, 32'h7000_0001);
    tick();
    chk("R9 clash falls", {31'b0, clash_err}, 32'h0);

    // R12: reset-type entry accepted while BL=1
    take_req = 1'b1; take_is_reset = 1'b1; take_code = 14'h3FFF;
    cur_pc = 32'h0BAD_F00C; cur_gr = 32'h0;
    tick();
    chk("R12 spc", spc_q, 32'h0BAD_F00C);
    chk("R12 ssr", ssr_q, 32'h7000_0001);
    chk("R12 evt", evt_q, 32'h0000_3FFF);
    chk("R12 redir", {31'b0, redir_vld}, 32'h1);

    // R11: return beats a same-cycle status write
    ret_req = 1'b1; sr_wr_en = 1'b1; sr_wr_data = 32'hFFFF_FFFF;
    tick();
    chk("R11 return wins", sr_q, 32'h7000_0001);
    chk("R11 return target", redir_addr, 32'h0BAD_F00C);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule